// File: doc/BRIEF.md
# Crystal oscillator power-up sequencer

This block sequences the start of an external crystal oscillator and decides when its clock may reach the logic that depends on it. It drives the oscillator's power control from a power-down request. After power-up it counts ticks of a slow reference, but only while the oscillator reports power-good. It compares that count against two separately programmed waits. The shorter one usually marks the oscillator as stable. The other one opens the clock enable for the internal digital logic.

The block also handles the choice of clock source. A request to move onto the RC oscillator is taken at once. A request to move back onto the crystal is held off until the crystal is reported stable, so the downstream glitch-free mux never switches onto a clock that is not ready. A debug bypass forces the internal clock enable on. An output enable gates the crystal output. An ok-detector status is reported only while its detector is enabled.

Top module: `xosc_pwrup_seq`

## Requirements
- R1: In reset, the reference tick count is cleared and the source selection returns to crystal (`clk_src_sel` = 0). With bypass low, `sts_stable` and `dig_clk_en` then read 0.
- R2: `osc_power_on` is the inverse of `ctl_pwdn`. While `ctl_pwdn` is 1, `sts_stable` and the release condition are 0 in the same cycle and the tick count restarts from zero.
- R3: A reference tick advances the count only on a clock edge where `ref_tick`, `osc_pgood` and power-on are all 1. Ticks while power-good is low are not counted.
- R4: `sts_stable` reads 1 once the count has reached 2^(`ctl_stab_dly`+1) ticks, and 0 before that. The code is 2 bits wide.
- R5: With bypass low, `dig_clk_en` reads 1 once the count has reached 2^(`ctl_rel_dly`+1) ticks, and 0 before that. The code is 3 bits wide.
- R6: `ctl_gate_bypass` = 1 forces `dig_clk_en` to 1 regardless of count or power state.
- R7: `xtal_clk_en` equals `ctl_out_en` AND NOT `ctl_pwdn`.
- R8: `sts_ok` equals `ctl_okdet_en` AND `osc_pgood` AND NOT `ctl_pwdn`. It is 0 whenever the detector is disabled.
- R9: `rc_clk_on` follows `ctl_rc_en`. A request for the RC source (`ctl_src_sel` = 1) appears on `clk_src_sel` one clock later.
- R10: A request for the crystal (`ctl_src_sel` = 0) leaves `clk_src_sel` unchanged while `sts_stable` is 0. It takes effect on the first clock edge at which `sts_stable` is 1.
- R11: The count saturates at the largest release threshold (256 ticks by default). A released clock stays released however many further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pwdn | input | 1 | Oscillator power-down request |
| ctl_out_en | input | 1 | Enable of the crystal output gate |
| ctl_okdet_en | input | 1 | Ok-detector enable |
| ctl_gate_bypass | input | 1 | Forces the internal clock enable on |
| ctl_rel_dly | input | 3 | Release wait code, 2^(code+1) ticks |
| ctl_stab_dly | input | 2 | Stabilisation wait code, 2^(code+1) ticks |
| ctl_src_sel | input | 1 | Source request: 0 crystal, 1 RC |
| ctl_rc_en | input | 1 | RC oscillator on |
| ref_tick | input | 1 | One-cycle slow reference tick |
| osc_pgood | input | 1 | Power-good from the oscillator model |
| osc_power_on | output | 1 | Oscillator power control |
| xtal_clk_en | output | 1 | Crystal output gate enable |
| dig_clk_en | output | 1 | Internal digital clock enable |
| clk_src_sel | output | 1 | Select to the glitch-free mux: 0 crystal, 1 RC |
| rc_clk_on | output | 1 | RC oscillator enable |
| sts_stable | output | 1 | Read-only stable status |
| sts_ok | output | 1 | Read-only ok-detector status |

## Verification
The bench probes the last tick below each threshold and the tick that reaches it. A comparator off by one, or one that ignores the code's top bit, shows up as a status that rises a tick early or late. It requests the crystal while the oscillator is still unstable, to catch a selector that switches early and hands the mux a clock that is not ready. It drives ticks while power-good is low, to catch a counter that ignores power-good. It powers down mid-count, to catch a counter that keeps its old value. It runs more than 512 ticks at the longest release code, where a counter that wraps instead of saturating would close the released clock again.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

    localparam int unsigned REL_CODE_W  = 3;
    localparam int unsigned STAB_CODE_W = 2;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_RC   = 1'b1
    } src_e;

    typedef struct packed {
        logic stable;
        logic ok;
    } xosc_status_t;

    function automatic int unsigned cnt_width(input int unsigned rel_w);
        return (1 << rel_w) + 1;
    endfunction

endpackage

// File: rtl/xosc_tick_counter.sv
module xosc_tick_counter #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] SAT_VAL = {1'b1, {(CNT_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (advance && (count != SAT_VAL)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/xosc_delay_match.sv
module xosc_delay_match #(
    parameter int unsigned CODE_W = 2,
    parameter int unsigned CNT_W  = 9
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CNT_W-1:0]  count,
    input  logic              hold_off,
    output logic              reached
);
    localparam int unsigned SH_W = CODE_W + 1;

    logic [SH_W-1:0]  shift_amt;
    logic [CNT_W-1:0] threshold;

    always_comb begin
        shift_amt = SH_W'(code) + SH_W'(1);
        threshold = {{(CNT_W-1){1'b0}}, 1'b1} << shift_amt;
        reached   = !hold_off && (count >= threshold);
    end
endmodule

// File: rtl/xosc_src_arbiter.sv
module xosc_src_arbiter
    import xosc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e request,
    input  logic xtal_ready,
    output src_e selected
);
    always_ff @(posedge clk) begin
        if (rst) begin
            selected <= SRC_XTAL;
        end else begin
            unique case (request)
                SRC_RC:   selected <= SRC_RC;
                SRC_XTAL: if (xtal_ready) selected <= SRC_XTAL;
                default:  selected <= selected;
            endcase
        end
    end
endmodule

// File: rtl/xosc_pwrup_seq.sv
module xosc_pwrup_seq
    import xosc_pkg::*;
#(
    parameter int unsigned REL_W  = REL_CODE_W,
    parameter int unsigned STAB_W = STAB_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_pwdn,
    input  logic              ctl_out_en,
    input  logic              ctl_okdet_en,
    input  logic              ctl_gate_bypass,
    input  logic [REL_W-1:0]  ctl_rel_dly,
    input  logic [STAB_W-1:0] ctl_stab_dly,
    input  logic              ctl_src_sel,
    input  logic              ctl_rc_en,
    input  logic              ref_tick,
    input  logic              osc_pgood,
    output logic              osc_power_on,
    output logic              xtal_clk_en,
    output logic              dig_clk_en,
    output logic              clk_src_sel,
    output logic              rc_clk_on,
    output logic              sts_stable,
    output logic              sts_ok
);
    localparam int unsigned CNT_W = cnt_width(REL_W);

    logic [CNT_W-1:0] tick_cnt;
    logic             stab_hit;
    logic             rel_hit;
    src_e             src_req;
    src_e             src_cur;
    xosc_status_t     status;

    xosc_tick_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk     (clk),
        .rst     (rst),
        .restart (ctl_pwdn),
        .advance (ref_tick && osc_pgood),
        .count   (tick_cnt)
    );

    xosc_delay_match #(.CODE_W(STAB_W), .CNT_W(CNT_W)) i_stab (
        .code     (ctl_stab_dly),
        .count    (tick_cnt),
        .hold_off (ctl_pwdn),
        .reached  (stab_hit)
    );

    xosc_delay_match #(.CODE_W(REL_W), .CNT_W(CNT_W)) i_rel (
        .code     (ctl_rel_dly),
        .count    (tick_cnt),
        .hold_off (ctl_pwdn),
        .reached  (rel_hit)
    );

    assign src_req = ctl_src_sel ? SRC_RC : SRC_XTAL;

    xosc_src_arbiter i_src (
        .clk        (clk),
        .rst        (rst),
        .request    (src_req),
        .xtal_ready (stab_hit),
        .selected   (src_cur)
    );

    always_comb begin
        status.stable = stab_hit;
        status.ok     = ctl_okdet_en && osc_pgood && !ctl_pwdn;
    end

    assign osc_power_on = !ctl_pwdn;
    assign xtal_clk_en  = ctl_out_en && !ctl_pwdn;
    assign dig_clk_en   = ctl_gate_bypass || rel_hit;
    assign clk_src_sel  = (src_cur == SRC_RC);
    assign rc_clk_on    = ctl_rc_en;
    assign sts_stable   = status.stable;
    assign sts_ok       = status.ok;
endmodule

// File: rtl/xosc_pwrup_seq_chk.sv
module xosc_pwrup_seq_chk #(
    parameter int unsigned STAB_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_pwdn,
    input logic              ctl_out_en,
    input logic              ctl_okdet_en,
    input logic              ctl_gate_bypass,
    input logic [STAB_W-1:0] ctl_stab_dly,
    input logic              osc_power_on,
    input logic              xtal_clk_en,
    input logic              dig_clk_en,
    input logic              clk_src_sel,
    input logic              sts_stable,
    input logic              sts_ok
);
    AST_PWDN_NOT_STABLE: assert property (@(posedge clk) disable iff (rst)
        ctl_pwdn |-> (!sts_stable && !osc_power_on)); // R2
    AST_STABLE_HELD: assert property (@(posedge clk) disable iff (rst)
        sts_stable |=> (sts_stable || ctl_pwdn || !$stable(ctl_stab_dly))); // R4
    AST_BYPASS_ON: assert property (@(posedge clk) disable iff (rst)
        ctl_gate_bypass |-> dig_clk_en); // R6
    AST_XOUT_GATED: assert property (@(posedge clk) disable iff (rst)
        xtal_clk_en |-> (ctl_out_en && osc_power_on)); // R7
    AST_OK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !ctl_okdet_en |-> !sts_ok); // R8
    AST_SRC_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (clk_src_sel && !sts_stable) |=> clk_src_sel); // R10
endmodule

bind xosc_pwrup_seq xosc_pwrup_seq_chk #(.STAB_W(STAB_W)) i_chk (
    .clk             (clk),
    .rst             (rst),
    .ctl_pwdn        (ctl_pwdn),
    .ctl_out_en      (ctl_out_en),
    .ctl_okdet_en    (ctl_okdet_en),
    .ctl_gate_bypass (ctl_gate_bypass),
    .ctl_stab_dly    (ctl_stab_dly),
    .osc_power_on    (osc_power_on),
    .xtal_clk_en     (xtal_clk_en),
    .dig_clk_en      (dig_clk_en),
    .clk_src_sel     (clk_src_sel),
    .sts_stable      (sts_stable),
    .sts_ok          (sts_ok)
);

// File: tb/test_xosc_pwrup_seq.sv
module test_xosc_pwrup_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_pwdn, ctl_out_en, ctl_okdet_en, ctl_gate_bypass;
    logic [2:0] ctl_rel_dly;
    logic [1:0] ctl_stab_dly;
    logic       ctl_src_sel, ctl_rc_en, ref_tick, osc_pgood;
    logic       osc_power_on, xtal_clk_en, dig_clk_en, clk_src_sel;
    logic       rc_clk_on, sts_stable, sts_ok;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    xosc_pwrup_seq i_xosc_pwrup_seq (
        .clk(clk), .rst(rst), .ctl_pwdn(ctl_pwdn), .ctl_out_en(ctl_out_en),
        .ctl_okdet_en(ctl_okdet_en), .ctl_gate_bypass(ctl_gate_bypass),
        .ctl_rel_dly(ctl_rel_dly), .ctl_stab_dly(ctl_stab_dly),
        .ctl_src_sel(ctl_src_sel), .ctl_rc_en(ctl_rc_en), .ref_tick(ref_tick),
        .osc_pgood(osc_pgood), .osc_power_on(osc_power_on),
        .xtal_clk_en(xtal_clk_en), .dig_clk_en(dig_clk_en),
        .clk_src_sel(clk_src_sel), .rc_clk_on(rc_clk_on),
        .sts_stable(sts_stable), .sts_ok(sts_ok)
    );

    // vector: [9]pwdn [8]out_en [7]okdet [6]bypass [5]pgood [4]rc_en
    //         [3]exp xtal_clk_en [2]exp sts_ok [1]exp dig_clk_en [0]exp rc_clk_on
    localparam logic [9:0] VEC [8] = '{
        10'b0100101000,
        10'b1110110001,
        10'b0010100100,
        10'b0010000000,
        10'b0111111111,
        10'b1001000010,
        10'b0100011001,
        10'b0001100010
    };

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic give_ticks(input int n);
        repeat (n) begin
            ref_tick = 1'b1;
            @(negedge clk);
        end
        ref_tick = 1'b0;
    endtask

    task automatic restart_count();
        ctl_pwdn = 1'b1;
        @(negedge clk);
        ctl_pwdn = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ctl_pwdn = 1'b1; ctl_out_en = 1'b0; ctl_okdet_en = 1'b0;
        ctl_gate_bypass = 1'b0; ctl_rel_dly = 3'd7; ctl_stab_dly = 2'd0;
        ctl_src_sel = 1'b0; ctl_rc_en = 1'b0; ref_tick = 1'b0; osc_pgood = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "src in reset", clk_src_sel, 1'b0);
        check("R1", "stable in reset", sts_stable, 1'b0);
        check("R1", "dig en in reset", dig_clk_en, 1'b0);
        rst = 1'b0;
        ctl_pwdn = 1'b0;
        @(negedge clk);
        check("R1", "stable after reset", sts_stable, 1'b0);
        check("R2", "power on", osc_power_on, 1'b1);

        // vector table, no ticks so the count stays below every threshold
        ctl_src_sel = 1'b1;
        for (int i = 0; i < 8; i++) begin
            {ctl_pwdn, ctl_out_en, ctl_okdet_en, ctl_gate_bypass, osc_pgood, ctl_rc_en} = VEC[i][9:4];
            @(negedge clk);
            check("R7", $sformatf("xtal en v%0d", i), xtal_clk_en, VEC[i][3]);
            check("R8", $sformatf("ok v%0d", i), sts_ok, VEC[i][2]);
            check("R6", $sformatf("dig en v%0d", i), dig_clk_en, VEC[i][1]);
            check("R9", $sformatf("rc on v%0d", i), rc_clk_on, VEC[i][0]);
            check("R2", $sformatf("power v%0d", i), osc_power_on, !VEC[i][9]);
        end
        check("R9", "rc source taken", clk_src_sel, 1'b1);

        // stabilisation and release thresholds, crystal request refused
        ctl_gate_bypass = 1'b0; osc_pgood = 1'b1;
        ctl_stab_dly = 2'd1; ctl_rel_dly = 3'd2;
        restart_count();
        ctl_src_sel = 1'b0;
        give_ticks(3);
        check("R4", "stable at 3 of 4", sts_stable, 1'b0);
        check("R10", "crystal refused", clk_src_sel, 1'b1);
        give_ticks(1);
        check("R4", "stable at 4 of 4", sts_stable, 1'b1);
        check("R10", "not yet switched", clk_src_sel, 1'b1);
        @(negedge clk);
        check("R10", "crystal taken", clk_src_sel, 1'b0);
        give_ticks(3);
        check("R5", "release at 7 of 8", dig_clk_en, 1'b0);
        give_ticks(1);
        check("R5", "release at 8 of 8", dig_clk_en, 1'b1);

        // power-down clears and restarts
        ctl_pwdn = 1'b1;
        @(negedge clk);
        check("R2", "stable cleared", sts_stable, 1'b0);
        check("R2", "release cleared", dig_clk_en, 1'b0);
        ctl_pwdn = 1'b0;
        @(negedge clk);
        check("R2", "count restarted", sts_stable, 1'b0);

        // ticks without power-good are not counted
        ctl_stab_dly = 2'd0;
        restart_count();
        osc_pgood = 1'b0;
        give_ticks(5);
        check("R3", "no count without pgood", sts_stable, 1'b0);
        osc_pgood = 1'b1;
        give_ticks(1);
        check("R3", "one counted tick", sts_stable, 1'b0);
        give_ticks(1);
        check("R3", "two counted ticks", sts_stable, 1'b1);

        // longest release and saturation
        ctl_rel_dly = 3'd7;
        restart_count();
        give_ticks(255);
        check("R11", "release at 255 of 256", dig_clk_en, 1'b0);
        give_ticks(1);
        check("R11", "release at 256", dig_clk_en, 1'b1);
        give_ticks(300);
        check("R11", "still released after 556", dig_clk_en, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule